// File: doc/BRIEF.md
# Multi-Slot Interrupt Status Controller

This block is the interrupt and status register file of a carrier board that hosts four plug-in modules. Every module has two interrupt request lines. Each slot has an 8-bit control register that enables its two lines and selects, per line, whether the line is edge- or level-sensitive. A shared 16-bit status register records the enabled request lines. It also holds four sticky timeout flags and mirrors four externally detected error flags.

The block drives one host interrupt output. Level-sensitive lines keep the output high for as long as any of them is recorded. An edge-sensitive line instead produces a single-cycle pulse when its recorded bit rises.

Software reaches the block through 16-bit register accesses at fixed offsets. Writing ones to the status register clears timeout flags and sends one-cycle acknowledge strobes back to the chosen module lines. Control fields for clock rate, recovery and the timeout and error interrupt enables are stored and read back, but they have no effect inside this block.

Top module: `irq_status_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every control register, the status register, the acknowledge strobes and the host interrupt output.
- R2: A write to offset 0x02, 0x04, 0x06 or 0x08 stores the low 8 data bits into the control register of slot 0, 1, 2 or 3 (slot = offset/2 − 1). A read of that offset returns the stored byte with the upper 8 bits zero. Control bits 7:6 enable lines 1/0 and bits 5:4 select edge mode for lines 1/0.
- R3: Offsets 0x00 (revision) and 0x0A (reset) and every unmapped offset read as zero, and writes to them change no control or status state.
- R4: Status bit 2n+k follows request line k of slot n one cycle later while that line's enable bit is set. While the enable bit is clear, the status bit holds its value whatever the request line does.
- R5: For a line in edge mode, a 0→1 change of its status bit raises the host interrupt for exactly the cycle in which the bit first reads 1. A 1→0 change causes nothing.
- R6: The host interrupt is high in every cycle in which any status request bit of a line not in edge mode is set, and it is low when no such bit is set and no edge pulse is due.
- R7: A one on timeout event n sets status bit 12+n one cycle later. Writing 1 to bit 12+n of the status register (offset 0x0C) clears it, and a set in the same cycle wins over the clear.
- R8: Writing 1 to status bit 2n+k drives acknowledge strobe 2n+k high for exactly the next cycle. The write does not change the status request bits.
- R9: Status bits 11:8 show the error flag inputs delayed by one cycle. Writes to those bits have no effect.
- R10: An edge pulse and a level assertion falling in the same cycle together give a high output, and the level assertion persists after the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| mod_req | input | 8 | Module request lines, bit 2n+k is slot n line k |
| tmo_evt | input | 4 | Timeout event per slot |
| err_flags | input | 4 | Error flags, mirrored into status bits 11:8 |
| mod_ack | output | 8 | One-cycle acknowledge strobe per module line |
| host_irq | output | 1 | Host interrupt output |

## Verification
The edge-mode pulse and the level-mode assertion can land in the same cycle. The bench provokes this by raising a level-mode line of slot 0 and an edge-mode line of slot 1 on the same clock. It then expects the output to be high on the first cycle and still high on the following cycle, when only the level state holds it. The output must drop once the level line falls, even though the edge line's status bit stays set. A timeout event that arrives together with a write-one-to-clear of the same flag is a second same-cycle collision, and the flag is expected to survive.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int SLOTS   = 4;
    localparam int LINES   = 2;
    localparam int REQ_W   = SLOTS * LINES;
    localparam int ERR_W   = 4;
    localparam int TMO_W   = SLOTS;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 16;
    localparam int CTRL_W  = 8;
    localparam int SLOT_IW = $clog2(SLOTS);

    localparam logic [ADDR_W-1:0] OFS_REVISION  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL_BASE = 8'h02;
    localparam logic [ADDR_W-1:0] OFS_SOFT_RST  = 8'h0A;
    localparam logic [ADDR_W-1:0] OFS_STATUS    = 8'h0C;

    // Per-slot control byte; field positions are software visible.
    typedef struct packed {
        logic [LINES-1:0] line_en;   // bits 7:6
        logic [LINES-1:0] edge_md;   // bits 5:4
        logic             err_ie;    // bit 3
        logic             tmo_ie;    // bit 2
        logic             recover;   // bit 1
        logic             clk_rate;  // bit 0
    } slot_ctrl_t;

    // Shared status word: timeouts 15:12, errors 11:8, requests 7:0.
    typedef struct packed {
        logic [TMO_W-1:0] tmo;
        logic [ERR_W-1:0] err;
        logic [REQ_W-1:0] req;
    } stat_t;

    typedef struct packed {
        logic               hit;
        logic [SLOT_IW-1:0] idx;
    } slot_sel_t;

    // Control offsets are spaced by two starting at OFS_CTRL_BASE.
    function automatic slot_sel_t decode_ctrl(input logic [ADDR_W-1:0] a);
        slot_sel_t s;
        s.hit = 1'b0;
        s.idx = '0;
        for (int n = 0; n < SLOTS; n++) begin
            if (a == OFS_CTRL_BASE + ADDR_W'(2 * n)) begin
                s.hit = 1'b1;
                s.idx = SLOT_IW'(n);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/irqc_regfile.sv
module irqc_regfile
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  stat_t             status_q,
    output logic [REQ_W-1:0]  en_q,
    output logic [REQ_W-1:0]  edge_q,
    output logic [REQ_W-1:0]  edge_d,
    output logic              stat_wr,
    output logic [DATA_W-1:0] rdata
);

    slot_ctrl_t [SLOTS-1:0] ctrl_q;
    slot_ctrl_t [SLOTS-1:0] ctrl_d;
    slot_sel_t              sel;
    logic                   past_ok;
    logic                   unused_hi_w;

    assign sel         = decode_ctrl(addr);
    assign unused_hi_w = ^wdata[DATA_W-1:CTRL_W];

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && sel.hit) begin
            ctrl_d[sel.idx] = slot_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            past_ok <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            past_ok <= 1'b1;
        end
    end

    assign stat_wr = wr_en && (addr == OFS_STATUS);

    // Revision and soft-reset offsets fall through to zero with the rest.
    always_comb begin
        rdata = '0;
        if (sel.hit) begin
            rdata = DATA_W'(ctrl_q[sel.idx]);
        end else if (addr == OFS_STATUS) begin
            rdata = DATA_W'(status_q);
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        for (genvar k = 0; k < LINES; k++) begin : g_line
            assign en_q[s*LINES+k]   = ctrl_q[s].line_en[k];
            assign edge_q[s*LINES+k] = ctrl_q[s].edge_md[k];
            assign edge_d[s*LINES+k] = ctrl_d[s].edge_md[k];
        end

        AST_CTRL_STORED: assert property (@(posedge clk) disable iff (rst)
            (past_ok && $past(wr_en && sel.hit && sel.idx == SLOT_IW'(s)))
            |-> (ctrl_q[s] == $past(slot_ctrl_t'(wdata[CTRL_W-1:0]))));  // R2
    end

    AST_OTHER_WRITE_NO_CTRL: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(wr_en && !sel.hit)) |-> $stable(ctrl_q));  // R3

endmodule

// File: rtl/irqc_status.sv
module irqc_status
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REQ_W-1:0]  line_en,
    input  logic [REQ_W-1:0]  mod_req,
    input  logic [TMO_W-1:0]  tmo_evt,
    input  logic [ERR_W-1:0]  err_in,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wdata,
    output stat_t             status_q,
    output stat_t             status_d,
    output logic [REQ_W-1:0]  ack_q
);

    stat_t            clr;
    logic [TMO_W-1:0] tmo_clr;
    logic             past_ok;
    logic             unused_err_w;

    assign clr          = stat_t'(wdata);
    assign tmo_clr      = stat_wr ? clr.tmo : '0;
    assign unused_err_w = ^clr.err;

    always_comb begin
        status_d.req = (mod_req & line_en) | (status_q.req & ~line_en);
        status_d.err = err_in;
        status_d.tmo = (status_q.tmo & ~tmo_clr) | tmo_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            ack_q    <= '0;
            past_ok  <= 1'b0;
        end else begin
            status_q <= status_d;
            ack_q    <= stat_wr ? clr.req : '0;
            past_ok  <= 1'b1;
        end
    end

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (((status_q.req ^ $past(status_q.req)) & ~$past(line_en)) == '0));  // R4

    AST_TMO_CLEARED: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((status_q.tmo & $past(tmo_clr & ~tmo_evt)) == '0));  // R7

    AST_ACK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && (ack_q != '0)) |-> $past(stat_wr));  // R8

    AST_ERR_MIRROR: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (status_q.err == $past(err_in)));  // R9

endmodule

// File: rtl/irqc_irq_gen.sv
module irqc_irq_gen
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REQ_W-1:0] req_q,
    input  logic [REQ_W-1:0] req_d,
    input  logic [REQ_W-1:0] edge_q,
    input  logic [REQ_W-1:0] edge_d,
    output logic             host_irq
);

    logic level_d;
    logic pulse_d;
    logic level_now;
    logic past_ok;

    // Level part uses only non-edge lines; edge part only fresh rises.
    assign level_d   = |(req_d & ~edge_d);
    assign pulse_d   = |(req_d & ~req_q & edge_d);
    assign level_now = |(req_q & ~edge_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            host_irq <= 1'b0;
            past_ok  <= 1'b0;
        end else begin
            host_irq <= level_d | pulse_d;
            past_ok  <= 1'b1;
        end
    end

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        level_now |-> host_irq);  // R6

    AST_PULSE_HAS_RISE: assert property (@(posedge clk) disable iff (rst)
        (past_ok && host_irq && !level_now)
        |-> ((req_q & ~$past(req_q) & edge_q) != '0));  // R5

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [REQ_W-1:0]  mod_req,
    input  logic [TMO_W-1:0]  tmo_evt,
    input  logic [ERR_W-1:0]  err_flags,
    output logic [REQ_W-1:0]  mod_ack,
    output logic              host_irq
);

    stat_t            status_q;
    stat_t            status_d;
    logic [REQ_W-1:0] en_q;
    logic [REQ_W-1:0] edge_q;
    logic [REQ_W-1:0] edge_d;
    logic             stat_wr;

    irqc_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .status_q (status_q),
        .en_q     (en_q),
        .edge_q   (edge_q),
        .edge_d   (edge_d),
        .stat_wr  (stat_wr),
        .rdata    (reg_rdata)
    );

    irqc_status u_status (
        .clk      (clk),
        .rst      (rst),
        .line_en  (en_q),
        .mod_req  (mod_req),
        .tmo_evt  (tmo_evt),
        .err_in   (err_flags),
        .stat_wr  (stat_wr),
        .wdata    (reg_wdata),
        .status_q (status_q),
        .status_d (status_d),
        .ack_q    (mod_ack)
    );

    irqc_irq_gen u_irq (
        .clk      (clk),
        .rst      (rst),
        .req_q    (status_q.req),
        .req_d    (status_d.req),
        .edge_q   (edge_q),
        .edge_d   (edge_d),
        .host_irq (host_irq)
    );

endmodule

// File: tb/irq_status_ctrl_bench.sv
`timescale 1ns/1ps
module irq_status_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic [7:0]  mod_req = 8'h00;
    logic [3:0]  tmo_evt = 4'h0;
    logic [3:0]  err_flags = 4'h0;
    logic [7:0]  mod_ack;
    logic        host_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    irq_status_ctrl u_irq_status_ctrl (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mod_req   (mod_req),
        .tmo_evt   (tmo_evt),
        .err_flags (err_flags),
        .mod_ack   (mod_ack),
        .host_irq  (host_irq)
    );

    // Behavioural reference model, updated on every rising edge.
    logic [7:0]  m_ctrl [4];
    logic [7:0]  n_ctrl [4];
    logic [15:0] m_st, n_st;
    logic [7:0]  m_ack;
    logic        m_irq;

    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < 4; n++) m_ctrl[n] = 8'h00;
            m_st  = 16'h0000;
            m_ack = 8'h00;
            m_irq = 1'b0;
        end else begin
            n_st = m_st;
            for (int i = 0; i < 8; i++)
                if (m_ctrl[i/2][6 + i%2]) n_st[i] = mod_req[i];
            n_st[11:8] = err_flags;
            for (int n = 0; n < 4; n++) begin
                if (reg_wr && reg_addr == 8'h0C && reg_wdata[12+n]) n_st[12+n] = 1'b0;
                if (tmo_evt[n]) n_st[12+n] = 1'b1;
            end
            m_ack = (reg_wr && reg_addr == 8'h0C) ? reg_wdata[7:0] : 8'h00;
            for (int n = 0; n < 4; n++) begin
                n_ctrl[n] = m_ctrl[n];
                if (reg_wr && reg_addr == 8'(2*n + 2)) n_ctrl[n] = reg_wdata[7:0];
            end
            m_irq = 1'b0;
            for (int i = 0; i < 8; i++) begin
                if (n_st[i] && !n_ctrl[i/2][4 + i%2]) m_irq = 1'b1;
                if (n_st[i] && n_ctrl[i/2][4 + i%2] && !m_st[i]) m_irq = 1'b1;
            end
            m_st = n_st;
            for (int n = 0; n < 4; n++) m_ctrl[n] = n_ctrl[n];
        end
    end

    function automatic logic [15:0] m_read(input logic [7:0] a);
        if (a == 8'h02 || a == 8'h04 || a == 8'h06 || a == 8'h08)
            return {8'h00, m_ctrl[a/2 - 1]};
        if (a == 8'h0C) return m_st;
        return 16'h0000;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        #3;
        if (mon_on) begin
            chk("R5/R6 model host_irq", {15'h0, host_irq}, {15'h0, m_irq});
            chk("R8 model mod_ack", {8'h00, mod_ack}, {8'h00, m_ack});
            chk("R2/R4 model reg_rdata", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        step();
        reg_wr    = 1'b0;
        reg_wdata = 16'h0000;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #2000000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        mon_on = 1'b1;
        step();

        // R1 reset state
        rd(8'h0C, 16'h0000, "R1 status after reset");
        rd(8'h02, 16'h0000, "R1 ctrl slot0 after reset");
        chk("R1 host_irq after reset", {15'h0, host_irq}, 16'h0);
        chk("R1 mod_ack after reset", {8'h0, mod_ack}, 16'h0);

        // R2 control store and readback
        wr(8'h02, 16'h00C0);
        rd(8'h02, 16'h00C0, "R2 ctrl slot0 readback");
        wr(8'h08, 16'hABCD);
        rd(8'h08, 16'h00CD, "R2 ctrl slot3 upper byte dropped");
        wr(8'h08, 16'h0000);
        rd(8'h08, 16'h0000, "R2 ctrl slot3 cleared");

        // R3 revision, reset and unmapped offsets
        wr(8'h00, 16'hFFFF);
        wr(8'h0A, 16'hFFFF);
        wr(8'h10, 16'hFFFF);
        wr(8'h03, 16'hFFFF);
        rd(8'h02, 16'h00C0, "R3 ctrl slot0 untouched");
        rd(8'h04, 16'h0000, "R3 ctrl slot1 untouched");
        rd(8'h0C, 16'h0000, "R3 status untouched");
        rd(8'h00, 16'h0000, "R3 revision reads zero");
        rd(8'h0A, 16'h0000, "R3 reset offset reads zero");
        rd(8'h0E, 16'h0000, "R3 unmapped reads zero");

        // R4 disabled line ignored; enabled line tracked; R6 level output
        mod_req[2] = 1'b1;
        step();
        step();
        rd(8'h0C, 16'h0000, "R4 disabled line not recorded");
        chk("R4 disabled line no irq", {15'h0, host_irq}, 16'h0);
        mod_req[0] = 1'b1;
        step();
        rd(8'h0C, 16'h0001, "R4 enabled line recorded");
        chk("R6 level irq high", {15'h0, host_irq}, 16'h1);
        mod_req[0] = 1'b0;
        step();
        rd(8'h0C, 16'h0000, "R4 enabled line follows fall");
        chk("R6 level irq low", {15'h0, host_irq}, 16'h0);
        mod_req[1] = 1'b1;
        step();
        rd(8'h0C, 16'h0002, "R4 line1 recorded");
        wr(8'h02, 16'h0000);
        mod_req[1] = 1'b0;
        step();
        rd(8'h0C, 16'h0002, "R4 status held while disabled");
        chk("R6 held level keeps irq", {15'h0, host_irq}, 16'h1);
        wr(8'h02, 16'h00C0);
        step();
        rd(8'h0C, 16'h0000, "R4 re-enabled line follows");
        chk("R6 irq low after release", {15'h0, host_irq}, 16'h0);

        // R5 edge mode: slot1 line0 enabled, edge
        wr(8'h04, 16'h0050);
        step();
        chk("R5 edge pulse on rise", {15'h0, host_irq}, 16'h1);
        rd(8'h0C, 16'h0004, "R5 edge status set");
        step();
        chk("R5 pulse lasts one cycle", {15'h0, host_irq}, 16'h0);
        mod_req[2] = 1'b0;
        step();
        chk("R5 no pulse on fall", {15'h0, host_irq}, 16'h0);
        rd(8'h0C, 16'h0000, "R5 edge status cleared");
        mod_req[2] = 1'b1;
        step();
        chk("R5 second rise pulses", {15'h0, host_irq}, 16'h1);
        step();
        chk("R5 second pulse ends", {15'h0, host_irq}, 16'h0);
        mod_req[2] = 1'b0;
        step();

        // R10 edge pulse and level assertion in the same cycle
        mod_req[0] = 1'b1;
        mod_req[2] = 1'b1;
        step();
        chk("R10 combined cycle high", {15'h0, host_irq}, 16'h1);
        rd(8'h0C, 16'h0005, "R10 both status bits");
        step();
        chk("R10 level persists after pulse", {15'h0, host_irq}, 16'h1);
        mod_req[0] = 1'b0;
        step();
        chk("R10 edge bit alone keeps no level", {15'h0, host_irq}, 16'h0);
        mod_req[2] = 1'b0;
        step();

        // R7 timeout set and write-one-to-clear
        tmo_evt = 4'b0101;
        step();
        tmo_evt = 4'b0000;
        rd(8'h0C, 16'h5000, "R7 timeouts set");
        wr(8'h0C, 16'h1000);
        rd(8'h0C, 16'h4000, "R7 timeout0 cleared");
        tmo_evt = 4'b0100;
        wr(8'h0C, 16'h4000);
        tmo_evt = 4'b0000;
        rd(8'h0C, 16'h4000, "R7 set wins over clear");
        wr(8'h0C, 16'hF000);
        rd(8'h0C, 16'h0000, "R7 all timeouts cleared");

        // R8 acknowledge strobes
        mod_req[0] = 1'b1;
        step();
        wr(8'h0C, 16'h0003);
        chk("R8 ack strobe", {8'h0, mod_ack}, 16'h0003);
        rd(8'h0C, 16'h0001, "R8 status request unchanged by ack");
        step();
        chk("R8 ack lasts one cycle", {8'h0, mod_ack}, 16'h0000);
        mod_req[0] = 1'b0;
        step();

        // R9 error mirror
        err_flags = 4'hA;
        step();
        rd(8'h0C, 16'h0A00, "R9 error flags mirrored");
        wr(8'h0C, 16'h0F00);
        rd(8'h0C, 16'h0A00, "R9 error write ignored");
        err_flags = 4'h0;
        step();
        rd(8'h0C, 16'h0000, "R9 error flags follow input");

        // R1 reset from a busy state
        mod_req[0] = 1'b1;
        step();
        chk("R1 busy before reset", {15'h0, host_irq}, 16'h1);
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
        rd(8'h02, 16'h0000, "R1 ctrl cleared by reset");
        rd(8'h0C, 16'h0000, "R1 status cleared by reset");
        chk("R1 irq cleared by reset", {15'h0, host_irq}, 16'h0);
        step();
        rd(8'h0C, 16'h0000, "R1 line disabled after reset");
        mod_req[0] = 1'b0;
        step();

        mon_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule